// File: doc/BRIEF.md
# Mixed-Size DRAM Bank Decoder

This block turns the top four address bits of a 20-bit address space into the control lines of a memory built from four DRAM banks of one-bit-wide chips. Each bank gets an active-high row-strobe enable and an active-low column strobe. The block also drives an active-low RAM select, an active-high ROM select, a column-strobe select and the ninth multiplexed DRAM address bit, which larger chips need and smaller chips ignore.

There are two memory maps. In the base map all four banks hold 64K. In the wide map banks 0 and 1 hold 64K each and banks 2 and 3 hold 256K each, which gives 640K of RAM in one contiguous range. The map is latched while reset is held. During a refresh cycle the DMA channel 0 acknowledge goes low, and every column strobe is then held off.

A two-state machine holds the map: `ST_BASE` or `ST_WIDE`. Each state has only one transition, to itself. The state is loaded from `map_sel_i` on every clock edge while `rst_n` is low. A 32-entry decode table is built from the current map. Five bits index the table: the acknowledge and the four segment bits. An output register loads the selected entry on each clock edge where the address strobe is high.

Top module: `dram_bank_decoder`

## Requirements
- R1: After reset and before the first strobed address, `bank_ras_en_o` is 0, `cas_n_o` is 4'b1111, `cas_sel_o` is 0, `ram_sel_n_o` is 1, `rom_sel_o` is 0, and both `ma8_row_o` and `ma8_col_o` are 0.
- R2: At most one bit of `bank_ras_en_o` is high at any time.
- R3: Base map (`map_sel_i`=0 during reset). Let seg = `addr_hi_i` (address bits 19..16). Segments 0 to 3 enable bank seg, bit seg of `bank_ras_en_o`. Segments 4 to 15 enable no bank.
- R4: Wide map (`map_sel_i`=1 during reset). Segment 0 enables bank 0 and segment 1 enables bank 1. Segments 2 to 5 enable bank 2 and segments 6 to 9 enable bank 3. Segments 10 to 15 enable no bank.
- R5: In both maps, `ma8_row_o` equals `addr_hi_i[0]` and `ma8_col_o` equals `addr_hi_i[1]`, taken from the strobed address.
- R6: `rom_sel_o` is 1 only for segment 15. Whenever it is 1, no bank is enabled and `ram_sel_n_o` is 1.
- R7: `ram_sel_n_o` is 0 exactly when one bank enable is high.
- R8: When `dack0_n_i` is high, `cas_n_o[i]` is the inverse of `bank_ras_en_o[i]`, and `cas_sel_o` is 1 when a bank is enabled. When `dack0_n_i` is low, `cas_n_o` is 4'b1111 and `cas_sel_o` is 0. Row enables are not affected by the acknowledge.
- R9: `map_sel_i` has no effect while `rst_n` is high. The map latched during reset stays in force until the next reset.
- R10: The outputs take the decode of the inputs present at a rising edge where `addr_strobe_i` is 1. They are visible one cycle later. On edges where `addr_strobe_i` is 0, the outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; `map_sel_i` is latched while it is low |
| map_sel_i | input | 1 | Map choice: 0 = base map (4 x 64K), 1 = wide map (2 x 64K + 2 x 256K) |
| addr_strobe_i | input | 1 | Address valid; loads the output register |
| addr_hi_i | input | 4 | Address bits 19..16 |
| dack0_n_i | input | 1 | DMA channel 0 acknowledge, active low; low means refresh |
| bank_ras_en_o | output | 4 | Row-strobe enable per bank, active high |
| cas_n_o | output | 4 | Column strobe per bank, active low |
| cas_sel_o | output | 1 | Column strobes allowed for a RAM access |
| ram_sel_n_o | output | 1 | RAM select, active low |
| rom_sel_o | output | 1 | ROM select for the top segment |
| ma8_row_o | output | 1 | Ninth DRAM address bit for the row phase |
| ma8_col_o | output | 1 | Ninth DRAM address bit for the column phase |

## Verification
Two things can happen in the same strobed cycle: a RAM bank hit and a refresh acknowledge. In that cycle the row enable must still show the bank while every column strobe stays blocked. The bench provokes this by sweeping all 32 combinations of segment and acknowledge in each map. A behavioural model predicts every output on every clock and is compared against the design, which catches a bank enable that leaks into a column strobe during refresh. Changes to the map input after reset, and cycles without a strobe, are mixed into the same run. The model checks that neither of them moves the outputs.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
    localparam int SEG_BITS  = 4;
    localparam int NUM_BANKS = 4;
    localparam int IDX_BITS  = SEG_BITS + 1;
    localparam int NUM_ENTRY = 1 << IDX_BITS;
    localparam int TOP_SEG   = (1 << SEG_BITS) - 1;

    localparam int BASE_RAM_END = NUM_BANKS;
    localparam int WIDE_B2_SEG  = 2;
    localparam int WIDE_B3_SEG  = 6;
    localparam int WIDE_RAM_END = 10;

    typedef enum logic {ST_BASE = 1'b0, ST_WIDE = 1'b1} map_state_e;

    typedef struct packed {
        logic [NUM_BANKS-1:0] ras_en;
        logic                 cas_sel;
        logic                 ram_sel_n;
        logic                 rom_sel;
    } dec_word_t;

    function automatic dec_word_t decode_entry(map_state_e mode, logic [IDX_BITS-1:0] idx);
        dec_word_t w;
        int seg;
        int lim;
        int bank;
        seg  = int'(idx[SEG_BITS-1:0]);
        lim  = (mode == ST_WIDE) ? WIDE_RAM_END : BASE_RAM_END;
        w    = '0;
        bank = 0;
        if (mode == ST_WIDE) begin
            if (seg < WIDE_B2_SEG)      bank = seg;
            else if (seg < WIDE_B3_SEG) bank = 2;
            else                        bank = 3;
        end else begin
            bank = seg % NUM_BANKS;
        end
        if (seg < lim) begin
            w.ras_en[bank] = 1'b1;
            w.ram_sel_n    = 1'b0;
            w.cas_sel      = idx[SEG_BITS];
        end else begin
            w.ram_sel_n    = 1'b1;
        end
        w.rom_sel = (seg == TOP_SEG);
        return w;
    endfunction
endpackage

// File: rtl/dbd_mode_fsm.sv
module dbd_mode_fsm
    import dbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       map_sel_i,
    output map_state_e mode_o
);
    map_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= map_sel_i ? ST_WIDE : ST_BASE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BASE: state_d = ST_BASE;
            ST_WIDE: state_d = ST_WIDE;
            default: state_d = ST_BASE;
        endcase
    end

    assign mode_o = state_q;

    // R9: map is frozen outside reset
    a_r9_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(state_q));
endmodule

// File: rtl/dbd_lut.sv
module dbd_lut
    import dbd_pkg::*;
(
    input  map_state_e          mode_i,
    input  logic [IDX_BITS-1:0] idx_i,
    output dec_word_t           word_o
);
    dec_word_t table_w [NUM_ENTRY];

    for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_entry
        assign table_w[e] = decode_entry(mode_i, IDX_BITS'(e));
    end

    assign word_o = table_w[idx_i];
endmodule

// File: rtl/dbd_out_reg.sv
module dbd_out_reg
    import dbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  dec_word_t            word_i,
    input  logic [1:0]           ma8_i,
    input  logic                 dack_n_i,
    output logic [NUM_BANKS-1:0] ras_en_o,
    output logic [NUM_BANKS-1:0] cas_n_o,
    output logic                 cas_sel_o,
    output logic                 ram_sel_n_o,
    output logic                 rom_sel_o,
    output logic [1:0]           ma8_o
);
    dec_word_t  word_q;
    logic [1:0] ma8_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '{ras_en: '0, cas_sel: 1'b0, ram_sel_n: 1'b1, rom_sel: 1'b0};
            ma8_q  <= '0;
        end else if (load_i) begin
            word_q <= word_i;
            ma8_q  <= ma8_i;
        end
    end

    always_comb begin
        ras_en_o    = word_q.ras_en;
        cas_n_o     = ~(word_q.ras_en & {NUM_BANKS{word_q.cas_sel}});
        cas_sel_o   = word_q.cas_sel;
        ram_sel_n_o = word_q.ram_sel_n;
        rom_sel_o   = word_q.rom_sel;
        ma8_o       = ma8_q;
    end

    // R2: one bank at most
    a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ras_en_o));
    // R6: ROM excludes RAM
    a_r6_rom_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel_o |-> (ras_en_o == '0) && ram_sel_n_o);
    // R8: refresh blanks column strobes
    a_r8_cas_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i) && !$past(dack_n_i)) |-> (&cas_n_o));
    // R10: hold without strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> ($stable(ras_en_o) && $stable(cas_n_o) && $stable(ma8_o)));
endmodule

// File: rtl/dram_bank_decoder.sv
module dram_bank_decoder
    import dbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_sel_i,
    input  logic                 addr_strobe_i,
    input  logic [SEG_BITS-1:0]  addr_hi_i,
    input  logic                 dack0_n_i,
    output logic [NUM_BANKS-1:0] bank_ras_en_o,
    output logic [NUM_BANKS-1:0] cas_n_o,
    output logic                 cas_sel_o,
    output logic                 ram_sel_n_o,
    output logic                 rom_sel_o,
    output logic                 ma8_row_o,
    output logic                 ma8_col_o
);
    map_state_e mode_w;
    dec_word_t  word_w;
    logic [1:0] ma8_w;

    dbd_mode_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_sel_i(map_sel_i),
        .mode_o   (mode_w)
    );

    dbd_lut i_lut (
        .mode_i(mode_w),
        .idx_i ({dack0_n_i, addr_hi_i}),
        .word_o(word_w)
    );

    dbd_out_reg i_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (addr_strobe_i),
        .word_i     (word_w),
        .ma8_i      (addr_hi_i[1:0]),
        .dack_n_i   (dack0_n_i),
        .ras_en_o   (bank_ras_en_o),
        .cas_n_o    (cas_n_o),
        .cas_sel_o  (cas_sel_o),
        .ram_sel_n_o(ram_sel_n_o),
        .rom_sel_o  (rom_sel_o),
        .ma8_o      (ma8_w)
    );

    assign ma8_row_o = ma8_w[0];
    assign ma8_col_o = ma8_w[1];

    // R7: RAM select tracks bank enables
    a_r7_ram_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_sel_n_o) == (bank_ras_en_o != '0));
endmodule

// File: tb/test_dram_bank_decoder.sv
module test_dram_bank_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       map_sel = 1'b0;
    logic       stb = 1'b0;
    logic [3:0] seg = 4'd0;
    logic       dack_n = 1'b1;
    logic [3:0] ras, cas_n;
    logic       cas_sel, ram_n, rom, m_row, m_col;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit         wide_m;
    logic [3:0] e_ras, e_cas_n;
    logic       e_cas_sel, e_ram_n, e_rom, e_row, e_col;

    always #10 clk = ~clk;

    dram_bank_decoder i_dram_bank_decoder (
        .clk(clk), .rst_n(rst_n), .map_sel_i(map_sel), .addr_strobe_i(stb),
        .addr_hi_i(seg), .dack0_n_i(dack_n), .bank_ras_en_o(ras), .cas_n_o(cas_n),
        .cas_sel_o(cas_sel), .ram_sel_n_o(ram_n), .rom_sel_o(rom),
        .ma8_row_o(m_row), .ma8_col_o(m_col)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_idle();
        e_ras = 4'b0; e_cas_n = 4'hF; e_cas_sel = 1'b0; e_ram_n = 1'b1;
        e_rom = 1'b0; e_row = 1'b0; e_col = 1'b0;
    endtask

    task automatic model_load(int s, bit dk);
        int b;
        b = -1;
        if (wide_m) begin
            if (s == 0) b = 0;
            else if (s == 1) b = 1;
            else if (s >= 2 && s <= 5) b = 2;
            else if (s >= 6 && s <= 9) b = 3;
        end else if (s < 4) b = s;
        e_ras = 4'b0;
        if (b >= 0) e_ras[b] = 1'b1;
        e_ram_n   = (b < 0);
        e_cas_sel = (b >= 0) && dk;
        e_cas_n   = e_cas_sel ? ~e_ras : 4'hF;
        e_rom     = (s == 15);
        e_row     = s[0];
        e_col     = s[1];
    endtask

    task automatic compare(string tag);
        chk({tag, " R3/R4 ras"}, 16'(ras), 16'(e_ras));
        chk({tag, " R8 cas_n"}, 16'(cas_n), 16'(e_cas_n));
        chk({tag, " R8 cas_sel"}, 16'(cas_sel), 16'(e_cas_sel));
        chk({tag, " R7 ram_n"}, 16'(ram_n), 16'(e_ram_n));
        chk({tag, " R6 rom"}, 16'(rom), 16'(e_rom));
        chk({tag, " R5 ma8"}, 16'({m_col, m_row}), 16'({e_col, e_row}));
        chk({tag, " R2 onehot"}, 16'($countones(ras) <= 1), 16'd1);
    endtask

    // one clock: drive at negedge, edge, check at next negedge
    task automatic cycle(bit s_stb, int s, bit dk, string tag);
        stb = s_stb; seg = 4'(s); dack_n = dk;
        @(negedge clk);
        if (s_stb) model_load(s, dk);
        compare(tag);
    endtask

    task automatic do_reset(bit w);
        @(negedge clk);
        rst_n = 1'b0; map_sel = w; stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wide_m = w;
        model_idle();
        @(negedge clk);
        compare("R1 reset");
    endtask

    initial begin
        model_idle();
        wide_m = 1'b0;
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            // R3/R4/R8: full sweep of segment x acknowledge
            for (int k = 0; k < 32; k++) begin
                cycle(1'b1, k % 16, k[4], m[0] ? "R4 sweep" : "R3 sweep");
                // R10: hold with changing inputs and no strobe
                cycle(1'b0, (k + 7) % 16, ~k[4], "R10 hold");
            end
            // R9: flip map input outside reset, map must not change
            map_sel = ~m[0];
            for (int s = 0; s < 16; s++) cycle(1'b1, s, 1'b1, "R9 frozen");
            map_sel = m[0];
        end
        // R1/R9: map taken again at next reset
        do_reset(1'b0);
        cycle(1'b1, 5, 1'b1, "R9 remap");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule